// File: doc/BRIEF.md
# Output Port Cell Filter with Knockout Concentrator

This block is the receiving end of one output port in a broadcast cell switch. In every slot (one clock cycle), all N inputs place their cell on their own lane of a broadcast bus. Each cell carries an internal destination tag. Every output port sees every lane. This block decides which of those cells belong to its port.

A cell belongs to the port when its tag equals the port's own identity. It also belongs when the multicast mask has the bit for that tag set. The matching cells then pass through a concentrator that takes at most L of them per slot and deliberately discards the rest. The cells it keeps go into an output FIFO that accepts several cells per slot and emits at most one per slot.

Two counters report loss. One counts cells rejected by the concentrator. The other counts cells that were accepted but found no room in the FIFO.

Top module: `cell_output_port`

## Requirements
- R1: A valid cell whose tag equals `port_id` is a match for this port; a valid cell with any other tag whose mask bit is clear is not.
- R2: A valid cell whose tag t has `mcast_mask[t]` set is a match, whatever `port_id` holds, so one port can take several tags.
- R3: A lane whose `in_valid` bit is low has no effect on the FIFO contents, the outputs or the counters, whatever its tag and data.
- R4: In one slot at most L_ACC matching cells are accepted, and these are the matching cells on the lowest-numbered lanes.
- R5: `knock_cnt` increases, in the cycle after the slot, by the number of matching cells beyond L_ACC in that slot. It wraps modulo 2^CNT_W.
- R6: Cells leave the port in arrival-slot order, and within one slot in ascending lane order. `out_src` gives the lane number.
- R7: In every cycle where the FIFO held at least one cell before the clock edge, exactly one cell is emitted, with `out_valid` high for one cycle. A cell stored at edge k appears at the earliest after edge k+1.
- R8: Free space is taken as DEPTH minus the occupancy before the edge. Accepted cells beyond that space are dropped, and the lowest lanes keep the room. `ovfl_cnt` rises by the number dropped.
- R9: While `rst_n` is low, the FIFO is empty, `out_valid` is low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_id | input | TAG_W | Unicast tag owned by this port |
| mcast_mask | input | 2**TAG_W | One bit per tag value to also accept |
| in_valid | input | N_IN | Per-lane cell present flag |
| in_tag | input | N_IN*TAG_W | Per-lane destination tag, lane i at bits i*TAG_W |
| in_data | input | N_IN*DATA_W | Per-lane cell body, lane i at bits i*DATA_W |
| out_valid | output | 1 | Emitted cell present |
| out_data | output | DATA_W | Emitted cell body |
| out_src | output | SRC_W | Lane the emitted cell came from |
| knock_cnt | output | CNT_W | Cells rejected by the concentrator |
| ovfl_cnt | output | CNT_W | Accepted cells dropped for lack of FIFO room |

## Verification
The bench hits slots where all sixteen lanes match together. A concentrator that keeps the wrong lanes, or miscounts the excess, would emit the wrong `out_src` sequence or drift `knock_cnt` away from the model. Back-to-back full slots fill the FIFO. A design that frees space by the same-cycle pop, or lets a high lane steal room from a low one, would disagree on `ovfl_cnt` and on the order of emitted cells. Slots with matching tags on invalid lanes, and phases that switch between unicast and multicast masks, expose filters that ignore the valid bit or the mask.

// File: rtl/cof_pkg.sv
package cof_pkg;
  localparam int DEF_N_IN   = 16;
  localparam int DEF_TAG_W  = 4;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_L_ACC  = 8;
  localparam int DEF_DEPTH  = 16;
  localparam int DEF_CNT_W  = 16;

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/cof_addr_filter.sv
module cof_addr_filter #(
  parameter int N_IN  = 16,
  parameter int TAG_W = 4
) (
  input  logic [N_IN-1:0]       in_valid,
  input  logic [N_IN*TAG_W-1:0] in_tag,
  input  logic [TAG_W-1:0]      port_id,
  input  logic [2**TAG_W-1:0]   mcast_mask,
  output logic [N_IN-1:0]       match
);
  for (genvar g = 0; g < N_IN; g++) begin : g_lane
    logic [TAG_W-1:0] tag;
    assign tag = in_tag[g*TAG_W +: TAG_W];
    assign match[g] = in_valid[g] && ((tag == port_id) || mcast_mask[tag]);
  end
endmodule

// File: rtl/cof_knockout.sv
module cof_knockout #(
  parameter int N_IN  = 16,
  parameter int L_ACC = 8,
  parameter int RK_W  = 5
) (
  input  logic [N_IN-1:0]      match,
  output logic [N_IN-1:0]      accept,
  output logic [N_IN*RK_W-1:0] rank,
  output logic [RK_W-1:0]      n_match,
  output logic [RK_W-1:0]      n_acc
);
  always_comb begin
    int run;
    run    = 0;
    accept = '0;
    rank   = '0;
    for (int i = 0; i < N_IN; i++) begin
      rank[i*RK_W +: RK_W] = RK_W'(run);
      accept[i] = match[i] && (run < L_ACC);
      if (match[i]) run = run + 1;
    end
    n_match = RK_W'(run);
    n_acc   = RK_W'(cof_pkg::min_int(run, L_ACC));
  end
endmodule

// File: rtl/cof_mw_fifo.sv
module cof_mw_fifo #(
  parameter int N_IN   = 16,
  parameter int DATA_W = 16,
  parameter int SRC_W  = 4,
  parameter int DEPTH  = 16,
  parameter int RK_W   = 5,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        accept,
  input  logic [N_IN*RK_W-1:0]   rank,
  input  logic [RK_W-1:0]        n_acc,
  input  logic [N_IN*DATA_W-1:0] in_data,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      out_data,
  output logic [SRC_W-1:0]       out_src,
  output logic [RK_W-1:0]        n_drop,
  output logic [AW:0]            occ
);
  logic [DATA_W-1:0] mem_d_q [DEPTH];
  logic [DATA_W-1:0] mem_d_nxt [DEPTH];
  logic [SRC_W-1:0]  mem_s_q [DEPTH];
  logic [SRC_W-1:0]  mem_s_nxt [DEPTH];
  logic [AW-1:0]     wptr_q, wptr_nxt, rptr_q, rptr_nxt;
  logic [AW:0]       occ_q, occ_nxt;
  logic              ov_q, ov_nxt;
  logic [DATA_W-1:0] od_q, od_nxt;
  logic [SRC_W-1:0]  os_q, os_nxt;
  logic              pop;
  logic [RK_W-1:0]   n_wr;

  always_comb begin
    int free_i;
    int wr_cnt;
    logic [AW-1:0] idx;
    mem_d_nxt = mem_d_q;
    mem_s_nxt = mem_s_q;
    free_i    = DEPTH - int'(occ_q);
    wr_cnt    = 0;
    for (int i = 0; i < N_IN; i++) begin
      idx = wptr_q + AW'(rank[i*RK_W +: RK_W]);
      if (accept[i] && (int'(rank[i*RK_W +: RK_W]) < free_i)) begin
        mem_d_nxt[idx] = in_data[i*DATA_W +: DATA_W];
        mem_s_nxt[idx] = SRC_W'(i);
        wr_cnt = wr_cnt + 1;
      end
    end
    n_wr     = RK_W'(wr_cnt);
    pop      = (occ_q != '0);
    n_drop   = n_acc - n_wr;
    occ_nxt  = occ_q + (AW+1)'(wr_cnt) - (AW+1)'(pop);
    wptr_nxt = wptr_q + AW'(wr_cnt);
    rptr_nxt = rptr_q + AW'(pop);
    ov_nxt   = pop;
    od_nxt   = pop ? mem_d_q[rptr_q] : od_q;
    os_nxt   = pop ? mem_s_q[rptr_q] : os_q;
  end

  always_ff @(posedge clk) begin
    mem_d_q <= mem_d_nxt;
    mem_s_q <= mem_s_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
      os_q   <= '0;
    end else begin
      wptr_q <= wptr_nxt;
      rptr_q <= rptr_nxt;
      occ_q  <= occ_nxt;
      ov_q   <= ov_nxt;
      od_q   <= od_nxt;
      os_q   <= os_nxt;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_src   = os_q;
  assign occ       = occ_q;
endmodule

// File: rtl/cell_output_port.sv
module cell_output_port
  import cof_pkg::*;
#(
  parameter int N_IN   = DEF_N_IN,
  parameter int TAG_W  = DEF_TAG_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int L_ACC  = DEF_L_ACC,
  parameter int DEPTH  = DEF_DEPTH,
  parameter int CNT_W  = DEF_CNT_W,
  localparam int SRC_W = $clog2(N_IN),
  localparam int RK_W  = $clog2(N_IN + 1),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TAG_W-1:0]       port_id,
  input  logic [2**TAG_W-1:0]    mcast_mask,
  input  logic [N_IN-1:0]        in_valid,
  input  logic [N_IN*TAG_W-1:0]  in_tag,
  input  logic [N_IN*DATA_W-1:0] in_data,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      out_data,
  output logic [SRC_W-1:0]       out_src,
  output logic [CNT_W-1:0]       knock_cnt,
  output logic [CNT_W-1:0]       ovfl_cnt
);
  logic [N_IN-1:0]      match_w, acc_w;
  logic [N_IN*RK_W-1:0] rank_w;
  logic [RK_W-1:0]      n_match_w, n_acc_w, n_drop_w;
  logic [AW:0]          occ_w;
  logic [CNT_W-1:0]     knock_q, knock_nxt, ovfl_q, ovfl_nxt;

  cof_addr_filter #(.N_IN(N_IN), .TAG_W(TAG_W)) u_filter (
    .in_valid(in_valid), .in_tag(in_tag), .port_id(port_id),
    .mcast_mask(mcast_mask), .match(match_w)
  );

  cof_knockout #(.N_IN(N_IN), .L_ACC(L_ACC), .RK_W(RK_W)) u_conc (
    .match(match_w), .accept(acc_w), .rank(rank_w),
    .n_match(n_match_w), .n_acc(n_acc_w)
  );

  cof_mw_fifo #(.N_IN(N_IN), .DATA_W(DATA_W), .SRC_W(SRC_W),
                .DEPTH(DEPTH), .RK_W(RK_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .accept(acc_w), .rank(rank_w),
    .n_acc(n_acc_w), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .out_src(out_src), .n_drop(n_drop_w), .occ(occ_w)
  );

  always_comb begin
    knock_nxt = knock_q + CNT_W'(n_match_w - n_acc_w);
    ovfl_nxt  = ovfl_q + CNT_W'(n_drop_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      knock_q <= '0;
      ovfl_q  <= '0;
    end else begin
      knock_q <= knock_nxt;
      ovfl_q  <= ovfl_nxt;
    end
  end

  assign knock_cnt = knock_q;
  assign ovfl_cnt  = ovfl_q;
endmodule

// File: rtl/cof_port_checker.sv
module cof_port_checker #(
  parameter int N_IN  = 16,
  parameter int L_ACC = 8,
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  parameter int OCC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IN-1:0]  in_valid,
  input logic [N_IN-1:0]  accept,
  input logic [OCC_W-1:0] occ,
  input logic             out_valid,
  input logic [CNT_W-1:0] knock_cnt,
  input logic [CNT_W-1:0] ovfl_cnt
);
  assert_accept_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(accept) <= L_ACC);

  assert_accept_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept & ~in_valid) == '0);

  assert_occ_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  assert_emit_from_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(occ) != '0));

  assert_knock_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == '0) |=> $stable(knock_cnt));

  assert_ovfl_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == '0) |=> $stable(ovfl_cnt));
endmodule

bind cell_output_port cof_port_checker #(
  .N_IN(N_IN), .L_ACC(L_ACC), .DEPTH(DEPTH), .CNT_W(CNT_W), .OCC_W(AW + 1)
) u_port_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .accept(acc_w),
  .occ(occ_w), .out_valid(out_valid), .knock_cnt(knock_cnt), .ovfl_cnt(ovfl_cnt)
);

// File: tb/test_cell_output_port.sv
`timescale 1ns/1ps
module test_cell_output_port;
  localparam int N = 16, TW = 4, DW = 16, L = 8, D = 16, CW = 16, SW = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [TW-1:0]   port_id;
  logic [2**TW-1:0] mcast_mask;
  logic [N-1:0]    in_valid;
  logic [N*TW-1:0] in_tag;
  logic [N*DW-1:0] in_data;
  logic            out_valid;
  logic [DW-1:0]   out_data;
  logic [SW-1:0]   out_src;
  logic [CW-1:0]   knock_cnt, ovfl_cnt;

  cell_output_port i_cell_output_port (
    .clk(clk), .rst_n(rst_n), .port_id(port_id), .mcast_mask(mcast_mask),
    .in_valid(in_valid), .in_tag(in_tag), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_src(out_src),
    .knock_cnt(knock_cnt), .ovfl_cnt(ovfl_cnt)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int qd[$], qs[$];
  int m_knock = 0, m_ovfl = 0, m_od = 0, m_os = 0;
  bit m_ov = 0;
  bit cmp_en = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: one slot per rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      qd.delete(); qs.delete();
      m_knock = 0; m_ovfl = 0; m_ov = 0;
    end else begin
      int free, nacc, nwr, t;
      free = D - qd.size();
      m_ov = (qd.size() > 0);
      if (m_ov) begin
        m_od = qd.pop_front();
        m_os = qs.pop_front();
      end
      nacc = 0; nwr = 0;
      for (int i = 0; i < N; i++) begin
        t = int'(in_tag[i*TW +: TW]);
        if (in_valid[i] && (t == int'(port_id) || mcast_mask[t])) begin
          if (nacc < L) begin
            nacc++;
            if (nwr < free) begin
              qd.push_back(int'(in_data[i*DW +: DW]));
              qs.push_back(i);
              nwr++;
            end else m_ovfl++;
          end else m_knock++;
        end
      end
      m_knock = m_knock % (1 << CW);
      m_ovfl  = m_ovfl % (1 << CW);
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check(out_valid == m_ov, "R7 out_valid", int'(out_valid), int'(m_ov));
      if (m_ov && out_valid) begin
        check(int'(out_data) == m_od, "R1/R2/R6 out_data", int'(out_data), m_od);
        check(int'(out_src) == m_os, "R4/R6 out_src", int'(out_src), m_os);
      end
      check(int'(knock_cnt) == m_knock, "R4/R5 knock_cnt", int'(knock_cnt), m_knock);
      check(int'(ovfl_cnt) == m_ovfl, "R8 ovfl_cnt", int'(ovfl_cnt), m_ovfl);
    end
  end

  int seq = 0;
  task automatic slot(input logic [N-1:0] v, input int tag_mode);
    // tag_mode: -1 random tag, else fixed tag value
    in_valid = v;
    for (int i = 0; i < N; i++) begin
      in_tag[i*TW +: TW] = (tag_mode < 0) ? TW'($urandom_range(0, 2**TW-1)) : TW'(tag_mode);
      in_data[i*DW +: DW] = DW'(seq);
      seq++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) slot('0, -1);
  endtask

  task automatic random_slots(input int n, input int pct);
    for (int k = 0; k < n; k++) begin
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = ($urandom_range(0, 99) < pct);
      slot(v, -1);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    port_id = 4'd5;
    mcast_mask = '0;
    in_valid = '0; in_tag = '0; in_data = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
    check(knock_cnt == '0, "R9 knock_cnt in reset", int'(knock_cnt), 0);
    check(ovfl_cnt == '0, "R9 ovfl_cnt in reset", int'(ovfl_cnt), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    // R1: unicast traffic, random tags
    random_slots(80, 40);
    idle(20);
    // R3: matching tags on invalid lanes
    slot('0, 5); slot('0, 5); slot('0, 5);
    check(out_valid == 1'b0, "R3 no output from invalid lanes", int'(out_valid), 0);
    idle(5);
    // R2: multicast mask with several tags
    mcast_mask = '0; mcast_mask[2] = 1'b1; mcast_mask[9] = 1'b1;
    random_slots(80, 40);
    idle(20);
    // R4/R5: all lanes match in one slot
    mcast_mask = '0;
    slot('1, 5);
    idle(20);
    // R8: consecutive full slots overflow the FIFO
    slot('1, 5); slot('1, 5); slot('1, 5); slot('1, 5); slot('1, 5);
    idle(30);
    // high-numbered lanes only, then a knockout mix
    slot(16'hFF00, 5); slot(16'hFFF0, 5);
    idle(25);
    // R6/R8: heavy random load with broad mask
    mcast_mask = 16'h0F0F;
    random_slots(300, 70);
    idle(40);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule